// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Host Controller

This block sits between a clocked user port and an external asynchronous pseudo-SRAM. A request carries an 18-bit word address, a write flag, active-high byte enables and, for reads, a burst length. The controller turns each request into correctly timed strobes on the memory side: active-low chip enable, output enable, write enable and one select per byte lane, plus an address bus and a split data bus (input, output, output-enable) that a pad ring joins into one bidirectional bus. All memory timing is given as nanosecond parameters and converted at elaboration into whole clock cycles, rounded up, at the configured clock period.

Reads may be bursts of up to 16 words at consecutive addresses. When the memory's page mode is known to be switched on (a configuration input), a word that stays inside the current 16-word page, with chip enable held low, is fetched with the short in-page access time. Any other word uses the full random access time. The memory refreshes itself and limits how long chip enable may stay low, so the controller tracks the low time and briefly raises chip enable between burst words before the limit would be crossed. After reset the controller keeps the memory deselected for the power-up wait before it accepts any request. Writes are always single-word cycles.

Top module: `psram_host_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, chip enable, output enable, write enable and every byte select are high and the host does not drive the data bus.
- R2: After reset release, req_ready stays low and chip enable stays high for at least ceil(T_PWRUP_NS/period) cycles and at most two cycles more.
- R3: A write holds chip enable low for ceil(T_WC_NS/period) cycles (at least the write-enable pulse plus two); its first cycle has write enable high, then write enable is low for max(ceil(T_WEL_NS/period), ceil(T_DSU_NS/period)) cycles, then high again for at least one cycle with chip enable still low; output enable stays high and write data is driven for the whole cycle.
- R4: A read holds chip enable, output enable and the selected byte selects low with write enable high; the data bus is sampled at the end of the access window and rsp_valid is high for one cycle right after it, carrying that word.
- R5: A read request returns req_len+1 words (req_len counts words minus one) from consecutive addresses, one rsp_valid pulse per word in address order; addresses wrap at the top of the 18-bit space.
- R6: With cfg_page_en high when the read is accepted, a burst word whose address differs from the previous word only in bits [3:0] and that follows it without chip enable going high uses ceil(T_PAGE_NS/period) cycles; every other read word, and every word when cfg_page_en was low, uses ceil(T_RAND_NS/period) cycles.
- R7: Chip enable is never low for more than floor(T_CEMAX_NS/period) consecutive cycles; when the next burst word would cross that limit, chip enable and output enable go high for exactly one cycle and that word then uses the full random access time.
- R8: req_be bit 0 selects the low byte (data bits [7:0], select bit 0) and bit 1 the high byte; a write leaves a disabled lane unchanged in memory, and a read returns zero in a disabled lane of rsp_data whatever the bus carries.
- R9: The host drives the data bus only while a write is in progress; in any cycle with output enable low, and in the cycle before it, the data output enable is low.
- R10: req_ready is high only when the controller is idle after the power-up wait; a request is taken in a cycle with req_valid and req_ready both high, and req_ready is low from the next cycle until the transaction has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_en | input | 1 | Memory page mode is switched on; sampled when a read is taken |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = single-word write, 0 = read burst |
| req_addr | input | 18 | Word address (first word of a burst) |
| req_len | input | 4 | Read burst length minus one |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One read word is on rsp_data |
| rsp_data | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_dq_i | input | 16 | Data bus as seen from the memory |
| mem_dq_o | output | 16 | Data the host drives |
| mem_dq_oe | output | 1 | Host drives the data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bsel_n | output | 2 | Byte lane selects, active low, bit 0 = low byte |

## Verification
The interesting collision is at the last cycle of a burst word, where the page test and the chip-enable budget both rule on the next word in the same cycle: an in-page word may be cheap, yet still have to be preceded by a break. Page-mode bursts of 16 words from page-aligned and near-page-end starting addresses, with the low-time limit lowered on the bench, force the break to fall inside a page, right at a page crossing, and at the address wrap. They are judged by the exact cycle of the final response against a latency computed on the bench, by a memory model that returns garbage unless each word's address has been held long enough, and by a check on every chip-enable low run.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_IDLE,
    ST_READ,
    ST_BREAK,
    ST_WRITE
  } ctrl_state_e;

  // nanoseconds to cycles, rounded up, never below one cycle
  function automatic int unsigned ns_to_cyc_up(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  // nanoseconds to cycles, rounded down: used for upper limits
  function automatic int unsigned ns_to_cyc_down(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000) / clk_ps;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_pwrup_wait.sv
module psram_pwrup_wait #(
  parameter int unsigned WAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned W = $clog2(WAIT_CYC + 1);

  logic [W-1:0] cnt_q;
  logic         done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == W'(WAIT_CYC - 1)) done_q <= 1'b1;
      else                           cnt_q  <= cnt_q + W'(1);
    end
  end

  assign done = done_q;
endmodule

// File: rtl/psram_ce_guard.sv
module psram_ce_guard #(
  parameter int unsigned CEMAX_C = 1000,
  parameter int unsigned WAIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [WAIT_W-1:0] nxt_wait,
  output logic              fits
);
  localparam int unsigned RUN_W = $clog2(CEMAX_C + 2);

  // completed low cycles before the current one
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (ce_n) run_q <= '0;
    else           run_q <= run_q + RUN_W'(1);
  end

  // current cycle plus the next word's window must stay within the limit
  assign fits = (int'(run_q) + 1 + int'(nxt_wait)) <= int'(CEMAX_C);
endmodule

// File: rtl/psram_lane_mask.sv
module psram_lane_mask #(
  parameter int unsigned NB = 2
) (
  input  logic [NB-1:0]   lane_en,
  input  logic [NB*8-1:0] raw,
  output logic [NB*8-1:0] masked
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign masked[g*8 +: 8] = lane_en[g] ? raw[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/psram_host_ctrl.sv
module psram_host_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned PAGE_BITS     = 4,
  parameter int unsigned LEN_W         = 4,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_RAND_NS     = 55,
  parameter int unsigned T_PAGE_NS     = 15,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_WEL_NS      = 35,
  parameter int unsigned T_DSU_NS      = 23,
  parameter int unsigned T_CEMAX_NS    = 8000,
  parameter int unsigned T_PWRUP_NS    = 150000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_page_en,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [DATA_W-1:0]      mem_dq_i,
  output logic [DATA_W-1:0]      mem_dq_o,
  output logic                   mem_dq_oe,
  output logic                   mem_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [DATA_W/8-1:0]    mem_bsel_n
);
  localparam int unsigned NB      = DATA_W / 8;
  localparam int unsigned RND_C   = ns_to_cyc_up(T_RAND_NS, CLK_PERIOD_PS);
  localparam int unsigned PG_C    = ns_to_cyc_up(T_PAGE_NS, CLK_PERIOD_PS);
  localparam int unsigned WEL_C   = max_u(ns_to_cyc_up(T_WEL_NS, CLK_PERIOD_PS),
                                          ns_to_cyc_up(T_DSU_NS, CLK_PERIOD_PS));
  localparam int unsigned WR_C    = max_u(ns_to_cyc_up(T_WC_NS, CLK_PERIOD_PS), WEL_C + 2);
  localparam int unsigned CEMAX_C = ns_to_cyc_down(T_CEMAX_NS, CLK_PERIOD_PS);
  localparam int unsigned PU_C    = ns_to_cyc_up(T_PWRUP_NS, CLK_PERIOD_PS);
  localparam int unsigned CNT_W   = $clog2(max_u(RND_C, WR_C) + 1);

  function automatic logic same_page(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:PAGE_BITS] == b[ADDR_W-1:PAGE_BITS];
  endfunction

  ctrl_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              page_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic [NB-1:0]     bsel_n_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  // named internal events, also seen by the checker
  logic              pu_done;
  logic              ce_fits;
  logic              acc_end;
  logic              wr_end;
  logic              nxt_in_page;
  logic [ADDR_W-1:0] nxt_addr;
  logic [CNT_W-1:0]  nxt_wait;
  logic [DATA_W-1:0] rd_masked;

  assign nxt_addr    = addr_q + ADDR_W'(1);
  assign nxt_in_page = page_q && same_page(addr_q, nxt_addr);
  assign nxt_wait    = nxt_in_page ? CNT_W'(PG_C) : CNT_W'(RND_C);
  assign acc_end     = (state_q == ST_READ) && (cnt_q == '0);
  assign wr_end      = (state_q == ST_WRITE) && (cnt_q == CNT_W'(WR_C - 1));

  psram_pwrup_wait #(.WAIT_CYC(PU_C)) u_pwrup (
    .clk  (clk),
    .rst_n(rst_n),
    .done (pu_done)
  );

  psram_ce_guard #(.CEMAX_C(CEMAX_C), .WAIT_W(CNT_W)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n_q),
    .nxt_wait(nxt_wait),
    .fits    (ce_fits)
  );

  psram_lane_mask #(.NB(NB)) u_mask (
    .lane_en(~bsel_n_q),
    .raw    (mem_dq_i),
    .masked (rd_masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_POWER;
      cnt_q       <= '0;
      addr_q      <= '0;
      left_q      <= '0;
      page_q      <= 1'b0;
      wdata_q     <= '0;
      ce_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
      bsel_n_q    <= '1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= acc_end;
      if (acc_end) rsp_data_q <= rd_masked;

      unique case (state_q)
        ST_POWER: if (pu_done) state_q <= ST_IDLE;

        ST_IDLE: begin
          if (req_valid) begin
            addr_q   <= req_addr;
            bsel_n_q <= ~req_be;
            ce_n_q   <= 1'b0;
            if (req_write) begin
              state_q <= ST_WRITE;
              cnt_q   <= '0;
              wdata_q <= req_wdata;
              dq_oe_q <= 1'b1;
            end else begin
              state_q <= ST_READ;
              cnt_q   <= CNT_W'(RND_C - 1);
              left_q  <= req_len;
              page_q  <= cfg_page_en;
              oe_n_q  <= 1'b0;
            end
          end
        end

        ST_READ: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (left_q == '0) begin
            state_q  <= ST_IDLE;
            ce_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            bsel_n_q <= '1;
          end else begin
            left_q <= left_q - LEN_W'(1);
            addr_q <= nxt_addr;
            if (ce_fits) begin
              cnt_q <= nxt_wait - CNT_W'(1);
            end else begin
              state_q <= ST_BREAK;
              ce_n_q  <= 1'b1;
              oe_n_q  <= 1'b1;
            end
          end
        end

        ST_BREAK: begin
          state_q <= ST_READ;
          cnt_q   <= CNT_W'(RND_C - 1);
          ce_n_q  <= 1'b0;
          oe_n_q  <= 1'b0;
        end

        ST_WRITE: begin
          if (wr_end) begin
            state_q  <= ST_IDLE;
            ce_n_q   <= 1'b1;
            we_n_q   <= 1'b1;
            dq_oe_q  <= 1'b0;
            bsel_n_q <= '1;
          end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            we_n_q <= (int'(cnt_q) + 1) > int'(WEL_C);
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_data   = rsp_data_q;
  assign mem_addr   = addr_q;
  assign mem_dq_o   = wdata_q;
  assign mem_dq_oe  = dq_oe_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_bsel_n = bsel_n_q;
endmodule

// File: rtl/psram_ctrl_checker.sv
module psram_ctrl_checker #(
  parameter int unsigned CEMAX_C = 1000,
  parameter int unsigned WEL_C   = 5
) (
  input logic clk,
  input logic rst_n,
  input logic pu_done,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_oe
);
  int unsigned ce_run;
  int unsigned we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_run <= 0;
      we_run <= 0;
    end else begin
      ce_run <= mem_ce_n ? 0 : ce_run + 1;
      we_run <= mem_we_n ? 0 : we_run + 1;
    end
  end

  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r2_pwrup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_done |-> (mem_ce_n && !req_ready));

  a_r3_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= WEL_C));

  a_r3_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

  a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  a_r4_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  a_r7_ce_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ce_run <= CEMAX_C);

  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));
endmodule

bind psram_host_ctrl psram_ctrl_checker #(
  .CEMAX_C(CEMAX_C),
  .WEL_C  (WEL_C)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pu_done  (pu_done),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/psram_host_ctrl_test.sv
module psram_host_ctrl_test;
  localparam int unsigned PER_NS   = 8;
  localparam int unsigned CEMAX_NS = 120;
  localparam int unsigned PWRUP_NS = 2000;

  function automatic int cyc_up(input int ns);
    return (ns + PER_NS - 1) / PER_NS;
  endfunction

  localparam int RND   = cyc_up(55);
  localparam int PG    = cyc_up(15);
  localparam int WEL   = 5;
  localparam int DSU   = cyc_up(23);
  localparam int CEMAX = CEMAX_NS / PER_NS;
  localparam int PU    = cyc_up(PWRUP_NS);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_page_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_i = 16'hDEAD;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [1:0]  mem_bsel_n;

  always #4 clk = ~clk;

  psram_host_ctrl #(.T_CEMAX_NS(CEMAX_NS), .T_PWRUP_NS(PWRUP_NS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bsel_n(mem_bsel_n)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // memory model storage (aliased on the low 10 address bits) and bench shadow
  logic [15:0] mdl [0:1023];
  logic [15:0] shd [0:1023];

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // expected cycle (counted from the accepting edge) of the last response
  function automatic int exp_last(input logic [17:0] a, input int len, input bit pg);
    int t = 0;
    int run = 0;
    for (int i = 0; i <= len; i++) begin
      logic [17:0] cur;
      logic [17:0] prv;
      int w;
      cur = a + 18'(i);
      prv = a + 18'(i) - 18'd1;
      if (i == 0) w = RND;
      else w = (pg && cur[17:4] == prv[17:4]) ? PG : RND;
      if (i > 0 && run + w > CEMAX) begin
        t = t + 1;
        run = 0;
        w = RND;
      end
      t = t + w;
      run = run + w;
    end
    return t + 1;
  endfunction

  // ---------------- memory model, evaluated away from the active edge
  logic [17:0] p_addr = '0;
  logic        p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  logic [15:0] p_dq = '0;
  logic [1:0]  p_bsel = 2'b11;
  int up_cnt = 0, lo_cnt = 0, ce_run = 0, we_low = 0, dq_stable = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ce_n) begin
        up_cnt = 0; lo_cnt = 0;
      end else if (!p_ce && mem_addr == p_addr) begin
        up_cnt++; lo_cnt++;
      end else if (!p_ce && mem_addr[17:4] == p_addr[17:4]) begin
        up_cnt++; lo_cnt = 1;
      end else begin
        up_cnt = 1; lo_cnt = 1;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n && up_cnt >= RND &&
          lo_cnt >= (cfg_page_en ? PG : RND)) begin
        logic [15:0] w;
        w = mdl[mem_addr[9:0]];
        mem_dq_i <= {mem_bsel_n[1] ? 8'hEE : w[15:8], mem_bsel_n[0] ? 8'hEE : w[7:0]};
      end else begin
        mem_dq_i <= 16'hDEAD;
      end
      // R9: bus released in the cycle before and during output enable low
      if (!mem_oe_n && p_oe)
        check(!mem_dq_oe && !p_dqoe, "R9", "dq_oe around oe_n fall", mem_dq_oe, 0);
      // write capture on write-enable rise (R3 timing)
      if (mem_dq_oe && mem_dq_o == p_dq && p_dqoe) dq_stable++;
      else dq_stable = mem_dq_oe ? 1 : 0;
      if (!mem_we_n) we_low++;
      if (mem_we_n && !p_we) begin
        check(we_low >= WEL && !mem_ce_n, "R3", "we_n low cycles", we_low, WEL);
        check(dq_stable > DSU, "R3", "data stable before we_n rise", dq_stable, DSU + 1);
        if (!p_bsel[0]) mdl[p_addr[9:0]][7:0]  = p_dq[7:0];
        if (!p_bsel[1]) mdl[p_addr[9:0]][15:8] = p_dq[15:8];
        we_low = 0;
      end
      // R7: chip-enable low run
      if (!mem_ce_n) ce_run++;
      else if (!p_ce) begin
        check(ce_run <= CEMAX, "R7", "ce_n low run", ce_run, CEMAX);
        ce_run = 0;
      end
    end
    p_addr = mem_addr; p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n;
    p_dqoe = mem_dq_oe; p_dq = mem_dq_o; p_bsel = mem_bsel_n;
  end

  // ---------------- request tasks
  task automatic issue();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10", "ready after accept", req_ready, 0);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    issue();
    if (be[0]) shd[a[9:0]][7:0]  = d[7:0];
    if (be[1]) shd[a[9:0]][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [17:0] a, input int len, input logic [1:0] be,
                         input bit pg, input string req);
    int cyc = 1;
    int got = 0;
    int last = 0;
    req_write = 1'b0; req_addr = a; req_len = 4'(len); req_be = be; cfg_page_en = pg;
    issue();
    while (got <= len && cyc < 400) begin
      if (rsp_valid) begin
        logic [17:0] ca;
        logic [15:0] e;
        ca = a + 18'(got);
        e = shd[ca[9:0]] & lane_mask(be);
        check(rsp_data === e, req, "read word", rsp_data, e);
        got++;
        last = cyc;
      end
      if (got <= len) begin
        @(negedge clk);
        cyc++;
      end
    end
    check(got == len + 1, "R5", "word count", got, len + 1);
    check(last == exp_last(a, len, pg), req, "last response cycle", last, exp_last(a, len, pg));
    @(negedge clk);
    check(!rsp_valid, "R5", "no extra response", rsp_valid, 0);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  // ---------------- main sequence
  initial begin
    int wait_cyc = 0;
    bit ce_ok = 1'b1;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 1024; i++) begin
      mdl[i] = init_word(i);
      shd[i] = init_word(i);
    end
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_bsel_n == 2'b11 && !mem_dq_oe && !req_ready,
          "R1", "bus during reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe, req_ready}, 7'b1111100);
    rst_n = 1'b1;
    while (!req_ready && wait_cyc < 1000) begin
      @(negedge clk);
      wait_cyc++;
      if (!mem_ce_n) ce_ok = 1'b0;
    end
    check(wait_cyc >= PU && wait_cyc <= PU + 2, "R2", "power-up wait cycles", wait_cyc, PU);
    check(ce_ok, "R2", "ce_n high during wait", ce_ok, 1);
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_bsel_n == 2'b11 && !mem_dq_oe,
          "R1", "idle bus", {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe}, 6'b111110);

    // R3/R4: write then read back, single words
    do_write(18'h00123, 16'hBEEF, 2'b11);
    do_read(18'h00123, 0, 2'b11, 1'b0, "R4");
    // R8: lane writes keep the other byte, lane reads zero the disabled byte
    do_write(18'h00123, 16'h1177, 2'b01);
    do_read(18'h00123, 0, 2'b11, 1'b0, "R8");
    do_write(18'h00124, 16'h99AA, 2'b10);
    do_read(18'h00124, 0, 2'b11, 1'b0, "R8");
    do_read(18'h00124, 0, 2'b10, 1'b0, "R8");
    do_read(18'h00123, 0, 2'b01, 1'b1, "R8");
    // R5: burst, page mode off
    do_read(18'h00040, 5, 2'b11, 1'b0, "R5");
    // R6: page mode inside a page, and across a page boundary
    do_read(18'h00080, 3, 2'b11, 1'b1, "R6");
    do_read(18'h0008C, 7, 2'b11, 1'b1, "R6");
    // R7: long page bursts run into the chip-enable limit; one wraps the address space
    do_read(18'h00100, 15, 2'b11, 1'b1, "R7");
    do_read(18'h3FFF8, 15, 2'b11, 1'b1, "R7");
    do_read(18'h00205, 15, 2'b11, 1'b0, "R7");

    // mixed random traffic
    for (int k = 0; k < 60; k++) begin
      logic [17:0] a;
      logic [1:0]  be;
      a  = 18'($urandom);
      be = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 2) == 0)
        do_write(a, 16'($urandom), be);
      else
        do_read(a, $urandom_range(0, 15), be, 1'($urandom_range(0, 1)), "R6");
    end

    repeat (4) @(negedge clk);
    check(req_ready && mem_ce_n && !mem_dq_oe, "R10", "idle at end",
          {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
    finish_run();
  end
endmodule